// File: doc/BRIEF.md
# Bi-orthogonal Walsh Keying Chip Modulator

This block turns a scrambled, bit-serial data stream into baseband I/Q chip streams for the two high-rate spread-spectrum modes. Incoming bits are gathered into 4-bit sign-magnitude groups. Each group picks one of eight 8-chip codes and sets its polarity. A complete symbol then goes out as eight consecutive chips, one per clock, with a strobe marking each chip.

In the binary mode, one group makes a symbol and the same chips drive both I and Q. In the quaternary mode, two groups make a symbol: the first group's code drives Q and the second group's code drives I. Every chip is also inverted when the phase reference is set. The phase reference is the differentially encoded value carried over from the end of the header.

A one-cycle `start` pulse marks the switch into the data field. On that pulse the block captures the mode and the phase reference, and it clears any partial collection. Input flow control lets the next symbol's bits arrive while the current symbol is being sent. A continuous input therefore produces a chip stream with no gaps.

Top module: `mbok_chip_mod`

## Requirements
- R1: After reset, `chip_stb`, `chip_i` and `chip_q` are 0 and `bit_ready` is 1. While `chip_stb` is 0, both chip outputs stay at 0.
- R2: The code word is chosen by the group's magnitude. The magnitude is the first three bits received, with the first bit as its LSB. Magnitudes 0 to 7 give hex 03, 0C, 30, 3F, 56, 59, 65, 6A. Chips go out LSB of the word first.
- R3: The fourth bit of a group is the sign. When it is 1, all eight chips of that group's word are inverted.
- R4: In binary mode (`quad`=0 captured at `start`), each symbol uses one group, and `chip_i` equals `chip_q` on every chip.
- R5: In quaternary mode (`quad`=1 captured at `start`), each symbol uses eight bits. Bits 1 to 4 form the group that drives `chip_q`, and bits 5 to 8 form the group that drives `chip_i`.
- R6: When `phase_ref` is 1 at the `start` pulse, every chip is inverted. Later changes on `phase_ref` have no effect until the next `start`.
- R7: A symbol is sent as exactly 8 chips, with `chip_stb` high on 8 consecutive cycles.
- R8: When bits arrive with no gaps, symbols follow each other with no idle cycle between their chips. When no complete symbol is waiting, `chip_stb` falls to 0 after the last chip.
- R9: `bit_ready` is 0 only when a complete symbol is waiting for the current one to finish. A bit is taken only on a cycle where `bit_valid` and `bit_ready` are both 1.
- R10: Changes on `quad` after the `start` pulse have no effect until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse at entry to the data field; captures the mode and the phase reference |
| quad | input | 1 | Mode select: 0 binary, 1 quaternary |
| phase_ref | input | 1 | Phase reference bit, captured at `start` |
| bit_in | input | 1 | Serial scrambled data bit |
| bit_valid | input | 1 | `bit_in` holds a valid bit |
| bit_ready | output | 1 | The block can take a bit this cycle |
| chip_i | output | 1 | I-channel chip |
| chip_q | output | 1 | Q-channel chip |
| chip_stb | output | 1 | A chip is present on `chip_i`/`chip_q` |

## Verification
The assertions assume that `start` is pulsed only while no chips are being sent. With that assumption, the counter that checks symbol length stays aligned to symbol boundaries. The assertions also assume that `bit_valid` behaves like any valid/ready source. The bench keeps to both assumptions: it always waits until `chip_stb` has fallen and the stream is idle before it pulses `start` again. It drives inputs only on falling edges and holds a bit until it sees `bit_ready` high.

// File: rtl/mbok_chip_mod.sv
module mbok_chip_mod (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic quad,
  input  logic phase_ref,
  input  logic bit_in,
  input  logic bit_valid,
  output logic bit_ready,
  output logic chip_i,
  output logic chip_q,
  output logic chip_stb
);
  localparam int CHIPS = 8;
  localparam int GRP   = 4;
  localparam int IW    = $clog2(CHIPS);
  localparam int CW    = $clog2(2*GRP + 1);

  logic            quad_r, ph_r, busy;
  logic [2*GRP-1:0] acc;
  logic [CW-1:0]   cnt, need;
  logic [IW-1:0]   idx;
  logic [CHIPS-1:0] sh_i, sh_q;
  logic            have_sym, last, load, take;

  function automatic logic [CHIPS-1:0] mwal(input logic [2:0] m);
    case (m)
      3'd0: mwal = 8'h03;
      3'd1: mwal = 8'h0C;
      3'd2: mwal = 8'h30;
      3'd3: mwal = 8'h3F;
      3'd4: mwal = 8'h56;
      3'd5: mwal = 8'h59;
      3'd6: mwal = 8'h65;
      default: mwal = 8'h6A;
    endcase
  endfunction

  function automatic logic [CHIPS-1:0] word(input logic [GRP-1:0] g, input logic ph);
    word = mwal(g[2:0]) ^ {CHIPS{g[3] ^ ph}};
  endfunction

  assign need      = quad_r ? CW'(2*GRP) : CW'(GRP);
  assign have_sym  = (cnt == need);
  assign last      = busy && (idx == IW'(CHIPS-1));
  assign load      = have_sym && (!busy || last);
  assign bit_ready = !have_sym || load;
  assign take      = bit_valid && bit_ready && !start;

  assign chip_stb = busy;
  assign chip_i   = busy & sh_i[0];
  assign chip_q   = busy & sh_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quad_r <= 1'b0;
      ph_r   <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
      busy   <= 1'b0;
      idx    <= '0;
      sh_i   <= '0;
      sh_q   <= '0;
    end else if (start) begin
      quad_r <= quad;
      ph_r   <= phase_ref;
      cnt    <= '0;
      busy   <= 1'b0;
      idx    <= '0;
    end else begin
      if (load) begin
        cnt <= take ? CW'(1) : '0;
        if (take) acc[0] <= bit_in;
      end else if (take) begin
        acc[cnt[IW-1:0]] <= bit_in;
        cnt <= cnt + CW'(1);
      end

      if (load) begin
        sh_q <= word(acc[GRP-1:0], ph_r);
        sh_i <= quad_r ? word(acc[2*GRP-1:GRP], ph_r) : word(acc[GRP-1:0], ph_r);
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        sh_q <= sh_q >> 1;
        sh_i <= sh_i >> 1;
        idx  <= idx + IW'(1);
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

module mbok_chip_mod_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic quad_r,
  input logic bit_ready,
  input logic chip_i,
  input logic chip_q,
  input logic chip_stb
);
  logic [2:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n || start) run <= '0;
    else if (chip_stb)   run <= run + 3'd1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_stb |-> (!chip_i && !chip_q));

  p_iq_same_binary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_stb && !quad_r) |-> (chip_i == chip_q));

  p_whole_symbol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_stb && $past(chip_stb) && !$past(start) && !start) |-> (run == 3'd0));

  p_stall_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_ready |-> chip_stb);

  p_start_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !chip_stb);
endmodule

bind mbok_chip_mod mbok_chip_mod_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .quad_r(quad_r),
  .bit_ready(bit_ready), .chip_i(chip_i), .chip_q(chip_q), .chip_stb(chip_stb)
);

// File: tb/mbok_chip_mod_tb.sv
module mbok_chip_mod_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, quad = 1'b0, phase_ref = 1'b0;
  logic bit_in = 1'b0, bit_valid = 1'b0;
  logic bit_ready, chip_i, chip_q, chip_stb;
  int   checks = 0, errors = 0, stalls = 0;

  always #2.5 clk = ~clk;

  mbok_chip_mod dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .quad(quad), .phase_ref(phase_ref),
    .bit_in(bit_in), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .chip_i(chip_i), .chip_q(chip_q), .chip_stb(chip_stb)
  );

  // {quad, phase, data bits (first bit = LSB), expected Q word, expected I word}
  localparam int NV = 6;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 8'h03, 8'h03},   // R2 mag0
    {1'b0, 1'b0, 8'h0D, 8'hA6, 8'hA6},   // R3 mag5 sign
    {1'b0, 1'b1, 8'h03, 8'hC0, 8'hC0},   // R6 mag3 inverted
    {1'b1, 1'b0, 8'h96, 8'h65, 8'hF3},   // R5 Q=mag6, I=mag1 sign
    {1'b1, 1'b1, 8'h4F, 8'h6A, 8'hA9},   // R5 R6
    {1'b0, 1'b1, 8'h0A, 8'h30, 8'h30}    // R3 R6 cancel
  };

  always @(negedge clk) if (bit_valid && !bit_ready) stalls++;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic q, input logic ph);
    @(negedge clk);
    start = 1'b1; quad = q; phase_ref = ph;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_bits(input int n, input logic [15:0] d);
    for (int k = 0; k < n; k++) begin
      bit_valid = 1'b1; bit_in = d[k];
      while (!bit_ready) @(negedge clk);
      @(negedge clk);
    end
    bit_valid = 1'b0;
  endtask

  task automatic grab(input int n, input string tag,
                      input logic [23:0] eq, input logic [23:0] ei);
    logic [23:0] gq = '0, gi = '0;
    int gaps = 0;
    while (!chip_stb) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (!chip_stb) gaps++;
      gq[k] = chip_q; gi[k] = chip_i;
      @(negedge clk);
    end
    chk(gaps == 0, {tag, " R7 R8 strobe run"}, gaps, 0);
    chk(gq == eq, {tag, " Q chips"}, gq, eq);
    chk(gi == ei, {tag, " I chips"}, gi, ei);
    chk(chip_stb == 1'b0, {tag, " R8 idle after last chip"}, chip_stb, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(chip_stb == 0 && chip_i == 0 && chip_q == 0, "R1 outputs in reset", {chip_stb, chip_i, chip_q}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_ready == 1 && chip_stb == 0, "R1 idle after reset", {bit_ready, chip_stb}, 2'b10);

    for (int v = 0; v < NV; v++) begin
      pulse_start(VEC[v][25], VEC[v][24]);
      fork
        send_bits(VEC[v][25] ? 8 : 4, {8'h00, VEC[v][23:16]});
        grab(8, $sformatf("vec%0d R2 R4 R5", v), {16'h0, VEC[v][15:8]}, {16'h0, VEC[v][7:0]});
      join
    end

    // R8: quaternary, two symbols back to back
    pulse_start(1'b1, 1'b0);
    fork
      send_bits(16, 16'h58B2);
      grab(16, "R8 quad gapless", {8'h0, 8'hFC, 8'h30}, {8'h0, 8'h59, 8'hC0});
    join

    // R9: binary, three groups continuous; input must stall, output gapless
    stalls = 0;
    pulse_start(1'b0, 1'b0);
    fork
      send_bits(12, 16'h07E1);
      grab(24, "R9 binary backpressure", {8'h6A, 8'h9A, 8'h0C}, {8'h6A, 8'h9A, 8'h0C});
    join
    chk(stalls > 0, "R9 ready dropped while symbol waiting", stalls, 1);

    // R6: phase change after start is ignored
    pulse_start(1'b0, 1'b0);
    phase_ref = 1'b1;
    fork
      send_bits(4, 16'h0004);
      grab(8, "R6 phase held", 24'h56, 24'h56);
    join

    // R10: mode change after start is ignored
    pulse_start(1'b0, 1'b1);
    quad = 1'b1;
    fork
      send_bits(4, 16'h0007);
      grab(8, "R10 mode held", 24'h95, 24'h95);
    join

    // R9: no bit taken without valid; idle stays quiet
    repeat (10) @(negedge clk);
    chk(chip_stb == 0 && bit_ready == 1, "R9 no valid no chips", {chip_stb, bit_ready}, 2'b01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R8 act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule